// File: doc/BRIEF.md
# External Bus Address-Latch and Program-Read Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus for an 8-bit microcontroller core: an active-high address-latch strobe and an active-low program-read strobe. It runs from the oscillator clock. A divide-by-two stage produces the internal state phase, and a machine cycle lasts six states, which is twelve oscillator periods. In every machine cycle the latch strobe fires twice and the program-read strobe falls twice. The read strobe falls only while code is fetched from external memory.

The core reports what kind of cycle it is running. A cycle flagged as an external data transfer drops its first latch pulse and both read strobes. A single writable register bit can silence the latch strobe to cut bus noise. While the bit is in force, the latch line is held high and a weak-pullup enable is raised. The hardware lifts that silence on its own during external data cycles, table-read instructions, idle, power down and emulation. It also has no effect while code is fetched externally. Idle parks both strobes high and power down parks both low. The state and phase indicators let the core and other bus logic line up with the strobes.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: The phase output toggles on every oscillator clock. The state index steps 0,1,2,3,4,5 and advances after phase 1, so a machine cycle spans twelve clocks. Call position t = 2*state_idx + phase. In reset, state_idx=5, phase=1, ale=0, psen_n=1 and ale_weak_pu=0, and the first clock after reset is t=0.
- R2: In a normal cycle, ale is high at t=0,1 and t=6,7 and low at every other position.
- R3: With ext_exec=1, psen_n is low at t=3,4,5 and t=9,10,11, which is one clock after each ale fall, for three clocks. With ext_exec=0, psen_n stays high.
- R4: cyc_movx is sampled only in the clock that leaves t=11, and it marks the whole following cycle. In a marked cycle the ale pulse at t=0,1 is skipped and psen_n stays high. A value of cyc_movx that is present only in the middle of a cycle has no effect.
- R5: A write with sfr_wr_en=1 and sfr_wr_addr=8'h8E loads the disable bit from sfr_wr_data bit 0. Other data bits are ignored. A write to any other address leaves the bit unchanged. Reset clears the bit.
- R6: While the disable bit is set and the disable is in force, ale is held at 1 and ale_weak_pu=1. Strobe outputs are registered, so a mode input takes effect on the next clock.
- R7: A marked external-data cycle, cyc_movc=1 or emu_mode=1 suspends the disable. While it is suspended, ale pulses as in R2/R4 and ale_weak_pu=0.
- R8: With ext_exec=1 the disable bit has no effect: ale and psen_n follow R2/R3 and ale_weak_pu=0.
- R9: idle_mode=1 holds ale=1 and psen_n=1. pdown_mode=1 holds ale=0 and psen_n=0 and overrides idle. In both modes ale_weak_pu=0.
- R10: ale is never 1 while psen_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_exec | input | 1 | Code is being fetched from external program memory |
| cyc_movx | input | 1 | Next machine cycle is an external data transfer (sampled at t=11) |
| cyc_movc | input | 1 | A table-read instruction is executing |
| idle_mode | input | 1 | Idle mode |
| pdown_mode | input | 1 | Power-down mode |
| emu_mode | input | 1 | In-circuit emulation mode |
| sfr_wr_en | input | 1 | Register write strobe |
| sfr_wr_addr | input | 8 | Register write address |
| sfr_wr_data | input | 8 | Register write data |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| ale_weak_pu | output | 1 | Latch strobe silenced; only the weak pullup holds the line |
| state_idx | output | 3 | Current state within the machine cycle (0..5) |
| phase | output | 1 | Divide-by-two phase within the state |

## Verification
The hardest case to reach is a suspension that depends on the latched data-transfer flag. The disable bit has to be written first. Then cyc_movx has to be presented across the single clock that leaves t=11. Only after that is the whole following cycle observed. To get there, the stimulus watches the state and phase outputs until they read state 5, phase 1, and changes inputs only at that point. It then records a full twelve-clock strobe pattern and compares it with an expected pattern. A separate case raises cyc_movx only in the middle of a cycle to show the sampling point.

// File: rtl/ebs_pkg.sv
`timescale 1ns/1ps
package ebs_pkg;
  // Strobe shape in oscillator clocks, within each half machine cycle
  localparam int ALE_HIGH_TICKS = 2;  // latch strobe width
  localparam int PSEN_LEAD      = 1;  // latch fall to read fall
  localparam int PSEN_LOW_TICKS = 3;  // read strobe width

  typedef struct packed {
    logic ext_exec;
    logic movc;
    logic idle;
    logic pdown;
    logic emu;
  } ebs_mode_t;
endpackage

// File: rtl/ebs_timebase.sv
`timescale 1ns/1ps
module ebs_timebase #(
  parameter int STATES = 6,
  localparam int SW = $clog2(STATES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] st_q,
  output logic          ph_q,
  output logic [SW-1:0] st_nxt,
  output logic          ph_nxt,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(STATES - 1);

  always_comb begin
    ph_nxt = ~ph_q;
    wrap   = ph_q && (st_q == LAST);
    if (!ph_q)     st_nxt = st_q;
    else if (wrap) st_nxt = '0;
    else           st_nxt = st_q + SW'(1);
  end

  // Divide-by-two phase plus state counter; reset parks at the last position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b1;
      st_q <= LAST;
    end else begin
      ph_q <= ph_nxt;
      st_q <= st_nxt;
    end
  end

  assert_phase_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ph_q != $past(ph_q)));
  assert_state_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= LAST);
  assert_state_holds_in_phase1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ph_q) |-> $stable(st_q));
endmodule

// File: rtl/ebs_ale_dis_reg.sv
`timescale 1ns/1ps
module ebs_ale_dis_reg #(
  parameter int              AW   = 8,
  parameter int              DW   = 8,
  parameter logic [AW-1:0]   ADDR = 8'h8E,
  parameter int              BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          dis_q
);
  logic hit;
  logic unused_data;

  assign hit         = wr_en && (wr_addr == ADDR);
  assign unused_data = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dis_q <= 1'b0;
    else if (hit) dis_q <= wr_data[BIT];
  end

  assert_foreign_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR) |=> $stable(dis_q));
  assert_idle_bus_keeps_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dis_q));
endmodule

// File: rtl/ebs_strobe_shaper.sv
`timescale 1ns/1ps
module ebs_strobe_shaper
  import ebs_pkg::*;
#(
  parameter int STATES = 6,
  localparam int SW = $clog2(STATES),
  localparam int TW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] st_nxt,
  input  logic          ph_nxt,
  input  logic          wrap,
  input  logic          cyc_movx,
  input  ebs_mode_t     mode,
  input  logic          dis_bit,
  output logic          ale,
  output logic          psen_n,
  output logic          ale_weak_pu
);
  localparam int PSEN_START = ALE_HIGH_TICKS + PSEN_LEAD;
  localparam int PSEN_END   = PSEN_START + PSEN_LOW_TICKS;

  logic          movx_q, movx_nxt;
  logic [TW-1:0] t_nxt, pos;
  logic          first_half, ale_slot, psen_slot;
  logic          suspend, dis_eff;
  logic          ale_d, psen_d, pu_d;

  always_comb begin
    // next position t = 2*state + phase
    t_nxt      = {st_nxt, ph_nxt};
    first_half = t_nxt < TW'(STATES);
    pos        = first_half ? t_nxt : t_nxt - TW'(STATES);
    ale_slot   = pos < TW'(ALE_HIGH_TICKS);
    psen_slot  = (pos >= TW'(PSEN_START)) && (pos < TW'(PSEN_END));

    // data-transfer mark is captured only when leaving the last position
    movx_nxt = wrap ? cyc_movx : movx_q;

    suspend = movx_nxt | mode.movc | mode.idle | mode.pdown | mode.emu;
    dis_eff = dis_bit & ~suspend & ~mode.ext_exec;

    if (mode.pdown) begin
      ale_d  = 1'b0;
      psen_d = 1'b0;
    end else if (mode.idle) begin
      ale_d  = 1'b1;
      psen_d = 1'b1;
    end else begin
      ale_d  = dis_eff | (ale_slot & ~(movx_nxt & first_half));
      psen_d = ~(mode.ext_exec & psen_slot & ~movx_nxt);
    end
    pu_d = dis_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      movx_q      <= 1'b0;
      ale         <= 1'b0;
      psen_n      <= 1'b1;
      ale_weak_pu <= 1'b0;
    end else begin
      movx_q      <= movx_nxt;
      ale         <= ale_d;
      psen_n      <= psen_d;
      ale_weak_pu <= pu_d;
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));
  assert_pullup_means_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ale_weak_pu |-> ale);
  assert_pdown_parks_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode.pdown)) |-> (!ale && !psen_n && !ale_weak_pu));
  assert_ext_exec_no_pullup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode.ext_exec)) |-> !ale_weak_pu);
  assert_idle_parks_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode.idle) && !$past(mode.pdown)) |-> (ale && psen_n));
endmodule

// File: rtl/ext_bus_strobe_gen.sv
`timescale 1ns/1ps
module ext_bus_strobe_gen
  import ebs_pkg::*;
#(
  parameter int                    STATES_PER_CYC = 6,
  parameter int                    SFR_AW         = 8,
  parameter int                    SFR_DW         = 8,
  parameter logic [SFR_AW-1:0]     ALE_DIS_ADDR   = 8'h8E,
  parameter int                    ALE_DIS_BIT    = 0
) (
  input  logic                              osc_clk,
  input  logic                              rst_n,
  input  logic                              ext_exec,
  input  logic                              cyc_movx,
  input  logic                              cyc_movc,
  input  logic                              idle_mode,
  input  logic                              pdown_mode,
  input  logic                              emu_mode,
  input  logic                              sfr_wr_en,
  input  logic [SFR_AW-1:0]                 sfr_wr_addr,
  input  logic [SFR_DW-1:0]                 sfr_wr_data,
  output logic                              ale,
  output logic                              psen_n,
  output logic                              ale_weak_pu,
  output logic [$clog2(STATES_PER_CYC)-1:0] state_idx,
  output logic                              phase
);
  localparam int SW = $clog2(STATES_PER_CYC);

  logic [SW-1:0] st_nxt;
  logic          ph_nxt, wrap, dis_bit;
  ebs_mode_t     mode;

  assign mode = '{ext_exec: ext_exec, movc: cyc_movc, idle: idle_mode,
                  pdown: pdown_mode, emu: emu_mode};

  ebs_timebase #(.STATES(STATES_PER_CYC)) u_timebase (
    .clk(osc_clk), .rst_n(rst_n),
    .st_q(state_idx), .ph_q(phase),
    .st_nxt(st_nxt), .ph_nxt(ph_nxt), .wrap(wrap)
  );

  ebs_ale_dis_reg #(
    .AW(SFR_AW), .DW(SFR_DW), .ADDR(ALE_DIS_ADDR), .BIT(ALE_DIS_BIT)
  ) u_dis_reg (
    .clk(osc_clk), .rst_n(rst_n),
    .wr_en(sfr_wr_en), .wr_addr(sfr_wr_addr), .wr_data(sfr_wr_data),
    .dis_q(dis_bit)
  );

  ebs_strobe_shaper #(.STATES(STATES_PER_CYC)) u_shaper (
    .clk(osc_clk), .rst_n(rst_n),
    .st_nxt(st_nxt), .ph_nxt(ph_nxt), .wrap(wrap),
    .cyc_movx(cyc_movx), .mode(mode), .dis_bit(dis_bit),
    .ale(ale), .psen_n(psen_n), .ale_weak_pu(ale_weak_pu)
  );
endmodule

// File: tb/ext_bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module ext_bus_strobe_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_exec = 0, cyc_movx = 0, cyc_movc = 0;
  logic       idle_mode = 0, pdown_mode = 0, emu_mode = 0;
  logic       sfr_wr_en = 0;
  logic [7:0] sfr_wr_addr = 0, sfr_wr_data = 0;
  logic       ale, psen_n, ale_weak_pu, phase;
  logic [2:0] state_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ext_bus_strobe_gen u_dut (
    .osc_clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .cyc_movx(cyc_movx),
    .cyc_movc(cyc_movc), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
    .emu_mode(emu_mode), .sfr_wr_en(sfr_wr_en), .sfr_wr_addr(sfr_wr_addr),
    .sfr_wr_data(sfr_wr_data), .ale(ale), .psen_n(psen_n),
    .ale_weak_pu(ale_weak_pu), .state_idx(state_idx), .phase(phase)
  );

  // {pu, cfg[ext,movx,movc,idle,pdown,emu,dis], ale[11:0], psen_n[11:0]}; bit t = position t
  localparam logic [31:0] VEC [0:14] = '{
    {1'b0, 7'b1000000, 12'h0C3, 12'h1C7},  // 0 normal external fetch
    {1'b0, 7'b0000000, 12'h0C3, 12'hFFF},  // 1 internal fetch
    {1'b0, 7'b1100000, 12'h0C0, 12'hFFF},  // 2 data cycle, external
    {1'b0, 7'b0100000, 12'h0C0, 12'hFFF},  // 3 data cycle, internal
    {1'b1, 7'b0000001, 12'hFFF, 12'hFFF},  // 4 disabled
    {1'b0, 7'b1000001, 12'h0C3, 12'h1C7},  // 5 disabled, external fetch
    {1'b0, 7'b0100001, 12'h0C0, 12'hFFF},  // 6 disabled, data cycle
    {1'b0, 7'b0010001, 12'h0C3, 12'hFFF},  // 7 disabled, table read
    {1'b0, 7'b0000011, 12'h0C3, 12'hFFF},  // 8 disabled, emulation
    {1'b0, 7'b0001001, 12'hFFF, 12'hFFF},  // 9 disabled, idle
    {1'b0, 7'b0000101, 12'h000, 12'h000},  // 10 disabled, power down
    {1'b0, 7'b1001000, 12'hFFF, 12'hFFF},  // 11 idle, external fetch
    {1'b0, 7'b1000100, 12'h000, 12'h000},  // 12 power down, external fetch
    {1'b0, 7'b0001100, 12'h000, 12'h000},  // 13 idle and power down
    {1'b0, 7'b1010000, 12'h0C3, 12'h1C7}   // 14 table read, external fetch
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:         return "R2 R3";
      2, 3:         return "R4";
      4:            return "R6";
      5:            return "R8";
      6, 7, 8, 14:  return "R7";
      default:      return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr_en = 1; sfr_wr_addr = a; sfr_wr_data = d;
    @(negedge clk);
    sfr_wr_en = 0;
    @(negedge clk);
  endtask

  // Stop at the negedge where position t=11 is shown
  task automatic wait_last();
    for (int g = 0; g < 40; g++) begin
      if (state_idx == 3'd5 && phase == 1'b1) return;
      @(negedge clk);
    end
  endtask

  task automatic run_cycle(input logic [11:0] e_ale, input logic [11:0] e_psen,
                           input logic e_pu, input string tag, input bit pulse);
    logic [11:0] a_ale, a_psen, a_pu;
    bit tick_ok, overlap;
    tick_ok = 1; overlap = 0;
    wait_last();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      a_ale[k]  = ale;
      a_psen[k] = psen_n;
      a_pu[k]   = ale_weak_pu;
      if ((int'(state_idx) * 2 + int'(phase)) != k) tick_ok = 0;
      if (ale && !psen_n) overlap = 1;
      if (pulse && k == 0) cyc_movx = 1;
      if (pulse && k == 9) cyc_movx = 0;
    end
    chk(tick_ok, "R1", "position sequence", 0, 0);
    chk(a_ale == e_ale, tag, "ale pattern", a_ale, e_ale);
    chk(a_psen == e_psen, tag, "psen_n pattern", a_psen, e_psen);
    chk(a_pu == {12{e_pu}}, tag, "weak pullup", a_pu, {12{e_pu}});
    chk(!overlap, "R10", "ale high while psen_n low", 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state_idx == 3'd5 && phase && !ale && psen_n && !ale_weak_pu, "R1",
        "reset state", {state_idx, phase, ale, psen_n, ale_weak_pu}, 7'b1011010);
    rst_n = 1;

    for (int i = 0; i < 15; i++) begin
      {ext_exec, cyc_movx, cyc_movc, idle_mode, pdown_mode, emu_mode} = VEC[i][30:25];
      sfr_write(8'h8E, {7'b0, VEC[i][24]});
      run_cycle(VEC[i][23:12], VEC[i][11:0], VEC[i][31], vec_tag(i), 1'b0);
      // second consecutive cycle must repeat the pattern
      run_cycle(VEC[i][23:12], VEC[i][11:0], VEC[i][31], vec_tag(i), 1'b0);
    end
    {ext_exec, cyc_movx, cyc_movc, idle_mode, pdown_mode, emu_mode} = '0;

    // R5: reset clears the disable bit
    sfr_write(8'h8E, 8'h01);
    run_cycle(12'hFFF, 12'hFFF, 1'b1, "R6", 1'b0);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && !ale_weak_pu, "R5", "outputs in reset",
        {ale, psen_n, ale_weak_pu}, 3'b010);
    rst_n = 1;
    run_cycle(12'h0C3, 12'hFFF, 1'b0, "R5", 1'b0);

    // R5: write to a neighbouring address is ignored
    sfr_write(8'h8F, 8'h01);
    run_cycle(12'h0C3, 12'hFFF, 1'b0, "R5", 1'b0);
    // R5: only data bit 0 matters
    sfr_write(8'h8E, 8'hFE);
    run_cycle(12'h0C3, 12'hFFF, 1'b0, "R5", 1'b0);
    sfr_write(8'h8E, 8'h01);
    run_cycle(12'hFFF, 12'hFFF, 1'b1, "R5", 1'b0);
    sfr_write(8'h8E, 8'h00);

    // R4: data-transfer flag present only mid-cycle has no effect
    ext_exec = 1;
    run_cycle(12'h0C3, 12'h1C7, 1'b0, "R4", 1'b1);
    run_cycle(12'h0C3, 12'h1C7, 1'b0, "R4", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule